// File: doc/BRIEF.md
# Serial-Peripheral-Aware Port Pin Override

This block is an eight-bit general-purpose I/O port. For every pin it holds a direction bit and an output bit, and the output bit also serves as the pull-up request while the pin is an input. It samples the pad inputs through a two-stage synchronizer, and it combines the register state with per-pin override requests to produce the pad output value, the output enable and the pull-up enable. Other peripherals reach a pin through four enable/value pairs: pull-up, direction, output value and digital-input enable. A pin whose peripheral drives all four pairs to zero acts as a plain GPIO.

An SPI controller supplies an enable flag and a role flag, master or slave. These take over the four upper pins: serial clock (bit 7), master-in/slave-out (bit 6), master-out/slave-in (bit 5) and slave select (bit 4). Depending on the role, each of these pins is either forced to be an input or keeps the direction set in its register bit. A pin that the SPI drives takes its value from the controller. When a pin is forced to input, its pull-up still follows the pin's output register bit. Software accesses the port through a small register interface. A write takes effect on a clock edge, and reads are combinational.

Top module: `spi_gpio_port`

## Requirements
- R1: While reset is asserted and right after it is released, the direction and output registers hold 0. Every pad is then an input with no pull-up, driving 0.
- R2: Register address 0 is direction and address 1 is output/pull-up, each 1 = set per pin. Both are written on the edge when reg_wr_en is high and read back on reg_rdata. Address 2 reads the synchronized pin values, and writes to it are ignored. Address 3 reads 0.
- R3: With the SPI disabled and no override enable set: pad_oe equals the direction register, pad_out equals the output register, and pad_pu equals the output register masked by the pins that are inputs.
- R4: As an SPI slave: bits 7, 5 and 4 are inputs whatever their direction bits hold. Bit 6 takes its direction from its register bit and drives spi_miso_o.
- R5: As an SPI master: bit 6 is an input whatever its direction bit holds. Bits 7, 5 and 4 take their direction from their register bits, bit 7 drives spi_sck_o and bit 5 drives spi_mosi_o.
- R6: A pin forced to input by the SPI has its pull-up equal to its output register bit.
- R7: With the SPI disabled, bits 7 to 4 follow R3 or the external overrides, like the other pins.
- R8: An external override enable set to 1 replaces the register-derived value with the paired override value. While the SPI is enabled, external overrides on bits 7 to 4 are ignored.
- R9: pad_pu is never 1 on a pin whose pad_oe is 1, even when the pull-up is overridden.
- R10: A change on pad_in appears on pin_in and on the address-2 read after the second rising clock edge, and not after the first.
- R11: A pin with digital-input override enable 1 and value 0 reads as 0 on pin_in and on the address-2 read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| spi_on | input | 1 | SPI enabled |
| spi_master | input | 1 | 1 = master role, 0 = slave role |
| spi_sck_o | input | 1 | Clock value driven by the SPI as master |
| spi_mosi_o | input | 1 | Data value driven by the SPI as master |
| spi_miso_o | input | 1 | Data value driven by the SPI as slave |
| ext_pu_oe | input | 8 | Pull-up override enables |
| ext_pu_ov | input | 8 | Pull-up override values |
| ext_dd_oe | input | 8 | Direction override enables |
| ext_dd_ov | input | 8 | Direction override values (1 = output) |
| ext_pv_oe | input | 8 | Output value override enables |
| ext_pv_ov | input | 8 | Output value override values |
| ext_die_oe | input | 8 | Digital-input override enables |
| ext_die_ov | input | 8 | Digital-input override values (0 = gate off) |
| pad_in | input | 8 | Raw pad inputs |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |
| pin_in | output | 8 | Synchronized, gated input taps |

## Verification
The pad outputs and the read data are combinational from the registers. A write is therefore due at the first rising edge after the strobe, and an override or SPI flag change is due at once. The bench drives inputs on falling edges and compares at the following falling edge, so it sees each written value one edge after the write. The synchronized input is due at the second edge. The bench checks after one edge that the old value is still present, and checks the new value after the second edge. The sweep covers every direction value in all three SPI modes, with two output patterns each. It computes the expected pads from the per-pin rules.

// File: rtl/spi_gpio_pkg.sv
package spi_gpio_pkg;

    typedef enum logic [1:0] {
        ADDR_DIR  = 2'd0,
        ADDR_PORT = 2'd1,
        ADDR_PIN  = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    // enable/value pairs steering one pin
    typedef struct packed {
        logic pu_oe;
        logic pu_ov;
        logic dd_oe;
        logic dd_ov;
        logic pv_oe;
        logic pv_ov;
        logic die_oe;
        logic die_ov;
    } pin_ovr_t;

endpackage

// File: rtl/spi_ovr_gen.sv
module spi_ovr_gen
    import spi_gpio_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int SCK_BIT  = 7,
    parameter int MISO_BIT = 6,
    parameter int MOSI_BIT = 5,
    parameter int SS_BIT   = 4
) (
    input  logic             spi_on,
    input  logic             spi_master,
    input  logic             spi_sck_o,
    input  logic             spi_mosi_o,
    input  logic             spi_miso_o,
    output pin_ovr_t         ovr [WIDTH],
    output logic [WIDTH-1:0] claim
);

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            ovr[i] = '0;
        end
        claim = '0;
        if (spi_on) begin
            claim[SCK_BIT]  = 1'b1;
            claim[MISO_BIT] = 1'b1;
            claim[MOSI_BIT] = 1'b1;
            claim[SS_BIT]   = 1'b1;
            if (spi_master) begin
                // clock and data out: direction stays with software
                ovr[SCK_BIT].pv_oe   = 1'b1;
                ovr[SCK_BIT].pv_ov   = spi_sck_o;
                ovr[MOSI_BIT].pv_oe  = 1'b1;
                ovr[MOSI_BIT].pv_ov  = spi_mosi_o;
                ovr[MISO_BIT].dd_oe  = 1'b1;
                ovr[MISO_BIT].dd_ov  = 1'b0;
            end else begin
                ovr[SCK_BIT].dd_oe   = 1'b1;
                ovr[SCK_BIT].dd_ov   = 1'b0;
                ovr[MOSI_BIT].dd_oe  = 1'b1;
                ovr[MOSI_BIT].dd_ov  = 1'b0;
                ovr[SS_BIT].dd_oe    = 1'b1;
                ovr[SS_BIT].dd_ov    = 1'b0;
                ovr[MISO_BIT].pv_oe  = 1'b1;
                ovr[MISO_BIT].pv_ov  = spi_miso_o;
            end
        end
    end

endmodule

// File: rtl/pin_ovr_cell.sv
module pin_ovr_cell
    import spi_gpio_pkg::*;
(
    input  logic     dir_bit,
    input  logic     port_bit,
    input  logic     sync_bit,
    input  pin_ovr_t ovr,
    output logic     pad_oe,
    output logic     pad_out,
    output logic     pad_pu,
    output logic     din
);

    logic pu_req;

    always_comb begin
        pad_oe  = ovr.dd_oe ? ovr.dd_ov : dir_bit;
        pad_out = ovr.pv_oe ? ovr.pv_ov : port_bit;
        pu_req  = ovr.pu_oe ? ovr.pu_ov : port_bit;
        pad_pu  = pu_req & ~pad_oe;
        din     = (ovr.die_oe & ~ovr.die_ov) ? 1'b0 : sync_bit;
    end

endmodule

// File: rtl/spi_gpio_port.sv
module spi_gpio_port
    import spi_gpio_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int SCK_BIT  = 7,
    parameter int MISO_BIT = 6,
    parameter int MOSI_BIT = 5,
    parameter int SS_BIT   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [1:0]       reg_addr,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata,
    input  logic             spi_on,
    input  logic             spi_master,
    input  logic             spi_sck_o,
    input  logic             spi_mosi_o,
    input  logic             spi_miso_o,
    input  logic [WIDTH-1:0] ext_pu_oe,
    input  logic [WIDTH-1:0] ext_pu_ov,
    input  logic [WIDTH-1:0] ext_dd_oe,
    input  logic [WIDTH-1:0] ext_dd_ov,
    input  logic [WIDTH-1:0] ext_pv_oe,
    input  logic [WIDTH-1:0] ext_pv_ov,
    input  logic [WIDTH-1:0] ext_die_oe,
    input  logic [WIDTH-1:0] ext_die_ov,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu,
    output logic [WIDTH-1:0] pin_in
);

    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] port;
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] sync;
    } port_state_t;

    port_state_t st_d, st_q;

    pin_ovr_t         spi_ovr [WIDTH];
    pin_ovr_t         ext_ovr [WIDTH];
    pin_ovr_t         use_ovr [WIDTH];
    logic [WIDTH-1:0] spi_claim;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pad_in;
        st_d.sync = st_q.meta;
        if (reg_wr_en) begin
            case (reg_addr)
                ADDR_DIR:  st_d.dir  = reg_wdata;
                ADDR_PORT: st_d.port = reg_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_DIR:  reg_rdata = st_q.dir;
            ADDR_PORT: reg_rdata = st_q.port;
            ADDR_PIN:  reg_rdata = pin_in;
            default:   reg_rdata = '0;
        endcase
    end

    spi_ovr_gen #(
        .WIDTH   (WIDTH),
        .SCK_BIT (SCK_BIT),
        .MISO_BIT(MISO_BIT),
        .MOSI_BIT(MOSI_BIT),
        .SS_BIT  (SS_BIT)
    ) spi_ovr_i (
        .spi_on    (spi_on),
        .spi_master(spi_master),
        .spi_sck_o (spi_sck_o),
        .spi_mosi_o(spi_mosi_o),
        .spi_miso_o(spi_miso_o),
        .ovr       (spi_ovr),
        .claim     (spi_claim)
    );

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        always_comb begin
            ext_ovr[g] = '{pu_oe:  ext_pu_oe[g],  pu_ov:  ext_pu_ov[g],
                           dd_oe:  ext_dd_oe[g],  dd_ov:  ext_dd_ov[g],
                           pv_oe:  ext_pv_oe[g],  pv_ov:  ext_pv_ov[g],
                           die_oe: ext_die_oe[g], die_ov: ext_die_ov[g]};
            use_ovr[g] = spi_claim[g] ? spi_ovr[g] : ext_ovr[g];
        end

        pin_ovr_cell cell_i (
            .dir_bit (st_q.dir[g]),
            .port_bit(st_q.port[g]),
            .sync_bit(st_q.sync[g]),
            .ovr     (use_ovr[g]),
            .pad_oe  (pad_oe[g]),
            .pad_out (pad_out[g]),
            .pad_pu  (pad_pu[g]),
            .din     (pin_in[g])
        );
    end

endmodule

// File: rtl/spi_gpio_port_chk.sv
module spi_gpio_port_chk #(
    parameter int WIDTH    = 8,
    parameter int SCK_BIT  = 7,
    parameter int MISO_BIT = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_addr,
    input logic [WIDTH-1:0] reg_rdata,
    input logic             spi_on,
    input logic             spi_master,
    input logic [WIDTH-1:0] ext_dd_oe,
    input logic [WIDTH-1:0] ext_die_oe,
    input logic [WIDTH-1:0] pad_in,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_pu,
    input logic [WIDTH-1:0] pin_in
);

    logic [1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (cyc_q != 2'd3) begin
            cyc_q <= cyc_q + 2'd1;
        end
    end

    AST_PU_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0); // R9

    AST_SLAVE_SCK_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_on && !spi_master) |-> !pad_oe[SCK_BIT]); // R4

    AST_MASTER_MISO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_on && spi_master) |-> !pad_oe[MISO_BIT]); // R5

    AST_FORCED_PU_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_on && !spi_master && reg_addr == 2'd1)
        |-> pad_pu[SCK_BIT] == reg_rdata[SCK_BIT]); // R6

    AST_PLAIN_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_on && ext_dd_oe == '0 && reg_addr == 2'd0)
        |-> pad_oe == reg_rdata); // R7

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2 && ext_die_oe == '0) |-> pin_in == $past(pad_in, 2)); // R10

endmodule

bind spi_gpio_port spi_gpio_port_chk #(
    .WIDTH   (WIDTH),
    .SCK_BIT (SCK_BIT),
    .MISO_BIT(MISO_BIT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .spi_on    (spi_on),
    .spi_master(spi_master),
    .ext_dd_oe (ext_dd_oe),
    .ext_die_oe(ext_die_oe),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .pin_in    (pin_in)
);

// File: tb/spi_gpio_port_tb_top.sv
`timescale 1ns/1ps
module spi_gpio_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_on = 1'b0, spi_master = 1'b0;
    logic       spi_sck_o = 1'b0, spi_mosi_o = 1'b0, spi_miso_o = 1'b0;
    logic [7:0] ext_pu_oe = '0, ext_pu_ov = '0, ext_dd_oe = '0, ext_dd_ov = '0;
    logic [7:0] ext_pv_oe = '0, ext_pv_ov = '0, ext_die_oe = '0, ext_die_ov = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe, pad_pu, pin_in;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    spi_gpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_on(spi_on),
        .spi_master(spi_master), .spi_sck_o(spi_sck_o), .spi_mosi_o(spi_mosi_o),
        .spi_miso_o(spi_miso_o), .ext_pu_oe(ext_pu_oe), .ext_pu_ov(ext_pu_ov),
        .ext_dd_oe(ext_dd_oe), .ext_dd_ov(ext_dd_ov), .ext_pv_oe(ext_pv_oe),
        .ext_pv_ov(ext_pv_ov), .ext_die_oe(ext_die_oe), .ext_die_ov(ext_die_ov),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .pin_in(pin_in)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // drive on falling edge, write lands at the next rising edge,
    // control returns at the falling edge after it
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // mode 0 = SPI off, 1 = slave, 2 = master
    function automatic void model(input int mode, input logic [7:0] d,
                                  input logic [7:0] p, input logic sck,
                                  input logic mosi, input logic miso,
                                  output logic [7:0] oe, output logic [7:0] out,
                                  output logic [7:0] pu);
        for (int i = 0; i < 8; i++) begin
            logic fin;
            fin = (mode == 1 && (i == 7 || i == 5 || i == 4)) ||
                  (mode == 2 && i == 6);
            oe[i] = fin ? 1'b0 : d[i];
            out[i] = p[i];
            if (mode == 2 && i == 7) out[i] = sck;
            if (mode == 2 && i == 5) out[i] = mosi;
            if (mode == 1 && i == 6) out[i] = miso;
            pu[i] = ~oe[i] & p[i];
        end
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] e_oe, e_out, e_pu;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1", "oe in reset", pad_oe, 8'h00);
        check("R1", "pu in reset", pad_pu, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out after reset", pad_out, 8'h00);
        reg_addr = 2'd0; #1;
        check("R1", "dir after reset", reg_rdata, 8'h00);

        // R2 register access
        wr(2'd0, 8'h3C);
        wr(2'd1, 8'hA5);
        wr(2'd2, 8'hFF);
        reg_addr = 2'd0; #1;
        check("R2", "dir readback", reg_rdata, 8'h3C);
        reg_addr = 2'd1; #1;
        check("R2", "port readback after pin write", reg_rdata, 8'hA5);
        reg_addr = 2'd3; #1;
        check("R2", "unused address", reg_rdata, 8'h00);
        check("R3", "oe", pad_oe, 8'h3C);
        check("R3", "pu", pad_pu, 8'hA5 & ~8'h3C);

        // sweep: every direction value, two output patterns, three modes
        for (int mode = 0; mode < 3; mode++) begin
            spi_on = (mode != 0);
            spi_master = (mode == 2);
            // in SPI modes, upper external overrides must be ignored (R8)
            ext_pu_oe = (mode != 0) ? 8'hF0 : 8'h00;
            ext_pu_ov = ext_pu_oe; ext_dd_oe = ext_pu_oe; ext_dd_ov = ext_pu_oe;
            ext_pv_oe = ext_pu_oe; ext_pv_ov = ext_pu_oe;
            for (int d = 0; d < 256; d++) begin
                for (int k = 0; k < 2; k++) begin
                    logic [7:0] pv;
                    pv = (k == 0) ? (8'(d) ^ 8'h5A) : ~8'(d);
                    spi_sck_o = pv[0]; spi_mosi_o = pv[1]; spi_miso_o = pv[2];
                    wr(2'd0, 8'(d));
                    wr(2'd1, pv);
                    model(mode, 8'(d), pv, pv[0], pv[1], pv[2], e_oe, e_out, e_pu);
                    if (mode == 0) begin
                        check("R7", "oe", pad_oe, e_oe);
                        check("R3", "out", pad_out, e_out);
                        check("R3", "pu", pad_pu, e_pu);
                    end else if (mode == 1) begin
                        check("R4", "oe", pad_oe, e_oe);
                        check("R8", "out", pad_out, e_out);
                        check("R6", "pu", pad_pu, e_pu);
                    end else begin
                        check("R5", "oe", pad_oe, e_oe);
                        check("R5", "out", pad_out, e_out);
                        check("R6", "pu", pad_pu, e_pu);
                    end
                end
            end
        end

        // external overrides with SPI off
        spi_on = 1'b0; spi_master = 1'b0;
        ext_pu_oe = '0; ext_pu_ov = '0; ext_dd_oe = '0; ext_dd_ov = '0;
        ext_pv_oe = '0; ext_pv_ov = '0;
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        ext_dd_oe = 8'h09; ext_dd_ov = 8'h08;
        ext_pv_oe = 8'h08; ext_pv_ov = 8'h08;
        ext_pu_oe = 8'h09; ext_pu_ov = 8'h09;
        #1;
        check("R8", "override oe", pad_oe, 8'h08);
        check("R8", "override out", pad_out, 8'h08);
        check("R9", "pu masked on driven pin", pad_pu, 8'h01);
        ext_pu_oe = '0; ext_pu_ov = '0; ext_dd_oe = '0; ext_dd_ov = '0;
        ext_pv_oe = '0; ext_pv_ov = '0;

        // R10 synchronizer delay
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        reg_addr = 2'd2;
        pad_in = 8'hC3;
        @(negedge clk);
        check("R10", "after one edge", pin_in, 8'h00);
        @(negedge clk);
        check("R10", "after two edges", pin_in, 8'hC3);
        check("R10", "pin read register", reg_rdata, 8'hC3);

        // R11 digital input gating
        ext_die_oe = 8'h81; ext_die_ov = 8'h01;
        #1;
        check("R11", "gated taps", pin_in, 8'h43);
        check("R11", "gated pin read", reg_rdata, 8'h43);
        ext_die_oe = '0; ext_die_ov = '0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule